// File: doc/BRIEF.md
# Legacy Sound DSP Host Port

This block is the register face that a host processor sees of a legacy sound-card command processor. It watches an 8-bit I/O offset window and gives five host ports. A reset port holds the command processor idle. A read-data port returns the bytes the processor produces. A command/status port passes command and operand bytes on and shows whether the processor is still busy. Two data-ready ports show whether a byte is waiting, and a read of either one acknowledges one of the two interrupt classes. Most ports answer at two adjacent offsets.

The command processor sits behind the block and uses a small handshake. A one-cycle command strobe goes out with the byte. A done pulse comes back when the byte has been consumed. A push carries each result byte, and raise pulses start each of the two interrupts. On entry to the reset state the block sends a stop pulse to the wave engine, and it holds a hold level to the processor for as long as the reset state lasts. Host reads are combinational from the current state. Their side effects (flag clears and counting) take place at the next clock edge.

Top module: `dsp_host_port`

## Requirements
- R1: After hardware reset the status port, both data-ready ports and the read-data port read 00h, and irq_std, irq_bx, cmd_valid, proc_hold and eng_stop are 0.
- R2: A host write to offset 0Ch or 0Dh outside the reset state pulses cmd_valid high for exactly one cycle, in the cycle after the write, with cmd_byte equal to the written byte.
- R3: A command write sets status bit 7 (busy). A proc_done pulse clears it, and the status port then reads 00h. A command write in the same cycle as proc_done leaves busy set.
- R4: Once busy is set, the fourth host read of the status port clears busy. All four of those reads return 80h and the next read returns 00h.
- R5: A proc_push stores proc_data in the read-data port (0Ah/0Bh) and sets bit 7 of both data-ready ports (0Eh, 0Fh) to 1. A host read of the read-data port clears that bit, so both ports then read 00h.
- R6: A push that arrives before the previous byte is read overwrites it. The read-data port returns the newest byte and the data-ready bit stays 1 until that read.
- R7: proc_irq_std sets irq_std and proc_irq_bx sets irq_bx. A read of 0Eh clears only irq_std and a read of 0Fh clears only irq_bx. A raise in the same cycle as the matching acknowledge wins.
- R8: Writing a byte with bit 0 = 1 to offset 06h or 07h enters the reset state. proc_hold rises, eng_stop pulses for one cycle, and busy, data-ready and both interrupts clear. Writing bit 0 = 0 leaves the reset state.
- R9: While in the reset state, command writes produce no cmd_valid and leave status at 00h, and raise pulses leave irq_std and irq_bx at 0.
- R10: Bits 6..0 of the status and data-ready ports read 0. Offsets outside the decoded set (including any offset with a nonzero upper nibble) read 00h, and writes to them have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low hardware reset |
| host_addr | input | 8 | Host I/O offset |
| host_wr | input | 1 | Host write strobe, one cycle per access |
| host_rd | input | 1 | Host read strobe, one cycle per access |
| host_wdata | input | 8 | Host write data |
| host_rdata | output | 8 | Host read data, combinational |
| cmd_valid | output | 1 | Command/operand byte strobe to the processor |
| cmd_byte | output | 8 | Command/operand byte |
| proc_done | input | 1 | Processor consumed the last byte |
| proc_push | input | 1 | Processor delivers a result byte |
| proc_data | input | 8 | Result byte |
| proc_irq_std | input | 1 | Raise the interrupt for the plain DMA command class |
| proc_irq_bx | input | 1 | Raise the interrupt for the extended DMA command class |
| irq_std | output | 1 | Interrupt, plain DMA class |
| irq_bx | output | 1 | Interrupt, extended DMA class |
| proc_hold | output | 1 | Processor held idle (reset state) |
| eng_stop | output | 1 | One-cycle stop pulse to the wave engine |

## Verification
The hardest case to reach is the point where busy is freed by status polling and not by the processor. The bench writes a command, withholds proc_done, and issues status reads on back-to-back cycles, so the fourth read is the one that clears the flag. The reset state is entered while busy, data-ready and an interrupt are all set at once, so that one write must clear all three. While the reset state is held, the bench then sends raise pulses and command writes that must have no effect. A second push before the first byte is read exercises the overwrite rule.

// File: rtl/dsp_host_pkg.sv
package dsp_host_pkg;

    localparam int DATA_W = 8;

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_RESET,
        SEL_DATA,
        SEL_CMD,
        SEL_ACK_STD,
        SEL_ACK_BX
    } port_sel_e;

    typedef struct packed {
        logic              hold;
        logic              busy;
        logic [2:0]        poll_cnt;
        logic              strobe;
        logic [DATA_W-1:0] byte_out;
        logic              stop;
    } cmd_state_t;

    typedef struct packed {
        logic [DATA_W-1:0] value;
        logic              avail;
    } data_state_t;

endpackage

// File: rtl/dsp_host_decode.sv
module dsp_host_decode
    import dsp_host_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic [ADDR_W-1:0] addr,
    output port_sel_e         sel
);
    localparam int LOW_W = 4;

    logic [LOW_W-1:0] low;
    logic             in_window;

    assign low = addr[LOW_W-1:0];

    generate
        if (ADDR_W > LOW_W) begin : g_upper
            assign in_window = (addr[ADDR_W-1:LOW_W] == '0);
        end else begin : g_flat
            assign in_window = 1'b1;
        end
    endgenerate

    always_comb begin
        sel = SEL_NONE;
        if (in_window) begin
            unique case (low)
                4'h6, 4'h7: sel = SEL_RESET;
                4'hA, 4'hB: sel = SEL_DATA;
                4'hC, 4'hD: sel = SEL_CMD;
                4'hE:       sel = SEL_ACK_STD;
                4'hF:       sel = SEL_ACK_BX;
                default:    sel = SEL_NONE;
            endcase
        end
    end
endmodule

// File: rtl/dsp_host_cmd.sv
module dsp_host_cmd
    import dsp_host_pkg::*;
#(
    parameter int POLL_LIMIT = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_reset,
    input  logic              wr_cmd,
    input  logic              rd_status,
    input  logic [DATA_W-1:0] wdata,
    input  logic              proc_done,
    output logic              hold_q,
    output logic              hold_now,
    output logic              busy,
    output logic              cmd_valid,
    output logic [DATA_W-1:0] cmd_byte,
    output logic              eng_stop
);
    localparam int CNT_W = 3;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(POLL_LIMIT - 1);

    cmd_state_t st_d, st_q;
    logic       enter;
    logic       leave;
    logic       take;

    assign enter    = wr_reset &  wdata[0];
    assign leave    = wr_reset & ~wdata[0];
    assign hold_now = st_q.hold | enter;
    assign take     = wr_cmd & ~hold_now;

    always_comb begin
        st_d        = st_q;
        st_d.strobe = 1'b0;
        st_d.stop   = 1'b0;

        if (enter) begin
            st_d.hold = 1'b1;
            st_d.stop = ~st_q.hold;
        end else if (leave) begin
            st_d.hold = 1'b0;
        end

        if (hold_now) begin
            st_d.busy     = 1'b0;
            st_d.poll_cnt = '0;
        end else if (take) begin
            st_d.busy     = 1'b1;
            st_d.poll_cnt = '0;
            st_d.strobe   = 1'b1;
            st_d.byte_out = wdata;
        end else if (proc_done) begin
            st_d.busy     = 1'b0;
            st_d.poll_cnt = '0;
        end else if (rd_status && st_q.busy) begin
            if (st_q.poll_cnt == LAST) begin
                st_d.busy     = 1'b0;
                st_d.poll_cnt = '0;
            end else begin
                st_d.poll_cnt = st_q.poll_cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign hold_q    = st_q.hold;
    assign busy      = st_q.busy;
    assign cmd_valid = st_q.strobe;
    assign cmd_byte  = st_q.byte_out;
    assign eng_stop  = st_q.stop;

    AST_CMD_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        take |=> (cmd_valid && cmd_byte == $past(wdata))); // R2
    AST_STROBE_SHORT: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid && !$past(take) |-> 1'b0); // R2
    AST_BUSY_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        take |=> busy); // R3
    AST_DONE_FREES: assert property (@(posedge clk) disable iff (!rst_n)
        (proc_done && !wr_cmd && !wr_reset) |=> !busy); // R3
    AST_HOLD_BLOCKS_CMD: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_cmd && hold_q) |=> (!cmd_valid && !busy)); // R9
    AST_STOP_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        eng_stop |=> !eng_stop); // R8
    AST_ENTER_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        enter |=> (hold_q && !busy)); // R8
endmodule

// File: rtl/dsp_host_data.sv
module dsp_host_data
    import dsp_host_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hold_now,
    input  logic              push,
    input  logic [DATA_W-1:0] pdata,
    input  logic              rd_data,
    output logic [DATA_W-1:0] value,
    output logic              avail
);
    data_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (hold_now) begin
            st_d.avail = 1'b0;
        end else if (push) begin
            st_d.value = pdata;
            st_d.avail = 1'b1;
        end else if (rd_data) begin
            st_d.avail = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign value = st_q.value;
    assign avail = st_q.avail;

    AST_PUSH_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        (push && !hold_now) |=> (avail && value == $past(pdata))); // R6
    AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_data && !push) |=> !avail); // R5
endmodule

// File: rtl/dsp_host_irq.sv
module dsp_host_irq #(
    parameter int NUM_IRQ = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               hold_q,
    input  logic               hold_now,
    input  logic [NUM_IRQ-1:0] raise,
    input  logic [NUM_IRQ-1:0] ack,
    output logic [NUM_IRQ-1:0] irq
);
    logic [NUM_IRQ-1:0] irq_d, irq_q;

    generate
        for (genvar i = 0; i < NUM_IRQ; i++) begin : g_line
            always_comb begin
                irq_d[i] = irq_q[i];
                if (hold_now) begin
                    irq_d[i] = 1'b0;
                end else if (raise[i]) begin
                    irq_d[i] = 1'b1;
                end else if (ack[i]) begin
                    irq_d[i] = 1'b0;
                end
            end

            AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
                (ack[i] && !raise[i]) |=> !irq[i]); // R7
            AST_RAISE_SETS: assert property (@(posedge clk) disable iff (!rst_n)
                (raise[i] && !hold_now) |=> irq[i]); // R7
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            irq_q <= '0;
        end else begin
            irq_q <= irq_d;
        end
    end

    assign irq = irq_q;

    AST_HOLD_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        hold_q |=> (irq == '0)); // R9
endmodule

// File: rtl/dsp_host_port.sv
module dsp_host_port
    import dsp_host_pkg::*;
#(
    parameter int ADDR_W     = 8,
    parameter int POLL_LIMIT = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic              host_wr,
    input  logic              host_rd,
    input  logic [DATA_W-1:0] host_wdata,
    output logic [DATA_W-1:0] host_rdata,
    output logic              cmd_valid,
    output logic [DATA_W-1:0] cmd_byte,
    input  logic              proc_done,
    input  logic              proc_push,
    input  logic [DATA_W-1:0] proc_data,
    input  logic              proc_irq_std,
    input  logic              proc_irq_bx,
    output logic              irq_std,
    output logic              irq_bx,
    output logic              proc_hold,
    output logic              eng_stop
);
    localparam int NUM_IRQ = 2;

    port_sel_e          sel;
    logic               wr_reset, wr_cmd, rd_status, rd_data;
    logic               hold_q, hold_now, busy, avail;
    logic [DATA_W-1:0]  data_val;
    logic [NUM_IRQ-1:0] raise, ack, irq;

    dsp_host_decode #(.ADDR_W(ADDR_W)) u_dec (
        .addr (host_addr),
        .sel  (sel)
    );

    assign wr_reset  = host_wr && sel == SEL_RESET;
    assign wr_cmd    = host_wr && sel == SEL_CMD;
    assign rd_status = host_rd && sel == SEL_CMD;
    assign rd_data   = host_rd && sel == SEL_DATA;
    assign ack[0]    = host_rd && sel == SEL_ACK_STD;
    assign ack[1]    = host_rd && sel == SEL_ACK_BX;
    assign raise     = {proc_irq_bx, proc_irq_std};

    dsp_host_cmd #(.POLL_LIMIT(POLL_LIMIT)) u_cmd (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_reset  (wr_reset),
        .wr_cmd    (wr_cmd),
        .rd_status (rd_status),
        .wdata     (host_wdata),
        .proc_done (proc_done),
        .hold_q    (hold_q),
        .hold_now  (hold_now),
        .busy      (busy),
        .cmd_valid (cmd_valid),
        .cmd_byte  (cmd_byte),
        .eng_stop  (eng_stop)
    );

    dsp_host_data u_data (
        .clk      (clk),
        .rst_n    (rst_n),
        .hold_now (hold_now),
        .push     (proc_push),
        .pdata    (proc_data),
        .rd_data  (rd_data),
        .value    (data_val),
        .avail    (avail)
    );

    dsp_host_irq #(.NUM_IRQ(NUM_IRQ)) u_irq (
        .clk      (clk),
        .rst_n    (rst_n),
        .hold_q   (hold_q),
        .hold_now (hold_now),
        .raise    (raise),
        .ack      (ack),
        .irq      (irq)
    );

    always_comb begin
        host_rdata = '0;
        unique case (sel)
            SEL_DATA:    host_rdata = data_val;
            SEL_CMD:     host_rdata = {busy, 7'b0};
            SEL_ACK_STD,
            SEL_ACK_BX:  host_rdata = {avail, 7'b0};
            default:     host_rdata = '0;
        endcase
    end

    assign irq_std   = irq[0];
    assign irq_bx    = irq[1];
    assign proc_hold = hold_q;

    AST_RESERVED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (sel == SEL_CMD || sel == SEL_ACK_STD || sel == SEL_ACK_BX) |-> (host_rdata[6:0] == 7'b0)); // R10
    AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (sel == SEL_NONE) |-> (host_rdata == '0)); // R10
endmodule

// File: tb/sim_dsp_host_port.sv
`timescale 1ns/1ps
module sim_dsp_host_port;
    localparam real HALF = 2.0;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] host_addr = '0;
    logic       host_wr = 1'b0, host_rd = 1'b0;
    logic [7:0] host_wdata = '0;
    logic [7:0] host_rdata;
    logic       cmd_valid;
    logic [7:0] cmd_byte;
    logic       proc_done = 1'b0, proc_push = 1'b0;
    logic [7:0] proc_data = '0;
    logic       proc_irq_std = 1'b0, proc_irq_bx = 1'b0;
    logic       irq_std, irq_bx, proc_hold, eng_stop;

    int checks = 0;
    int failures = 0;
    bit finished = 1'b0;

    logic [7:0] exp_q[$];
    string      tag_q[$];

    always #(HALF) clk = ~clk;

    dsp_host_port u0 (
        .clk(clk), .rst_n(rst_n), .host_addr(host_addr), .host_wr(host_wr),
        .host_rd(host_rd), .host_wdata(host_wdata), .host_rdata(host_rdata),
        .cmd_valid(cmd_valid), .cmd_byte(cmd_byte), .proc_done(proc_done),
        .proc_push(proc_push), .proc_data(proc_data), .proc_irq_std(proc_irq_std),
        .proc_irq_bx(proc_irq_bx), .irq_std(irq_std), .irq_bx(irq_bx),
        .proc_hold(proc_hold), .eng_stop(eng_stop)
    );

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
        end
    endtask

    // monitor: compares every host read against the scoreboard queue
    always @(negedge clk) begin
        #1;
        if (host_rd) begin
            if (exp_q.size() == 0) begin
                check("scoreboard-empty", 8'h01, 8'h00);
            end else begin
                check(tag_q.pop_front(), host_rdata, exp_q.pop_front());
            end
        end
    end

    task automatic clear_inputs();
        host_wr = 0; host_rd = 0; proc_done = 0; proc_push = 0;
        proc_irq_std = 0; proc_irq_bx = 0;
    endtask

    task automatic op_idle();
        @(negedge clk); clear_inputs();
    endtask

    task automatic op_wr(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk); clear_inputs();
        host_addr = a; host_wdata = d; host_wr = 1;
    endtask

    task automatic op_rd(input logic [7:0] a, input logic [7:0] exp, input string tag);
        @(negedge clk); clear_inputs();
        host_addr = a; host_rd = 1;
        exp_q.push_back(exp); tag_q.push_back(tag);
    endtask

    task automatic op_push(input logic [7:0] d);
        @(negedge clk); clear_inputs();
        proc_push = 1; proc_data = d;
    endtask

    task automatic op_done();
        @(negedge clk); clear_inputs(); proc_done = 1;
    endtask

    task automatic op_raise(input bit std, input bit bx);
        @(negedge clk); clear_inputs();
        proc_irq_std = std; proc_irq_bx = bx;
    endtask

    task automatic settle();
        #1;
    endtask

    initial begin
        #(4.0 * 200000);
        if (!finished) begin
            failures++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        // R1 reset state
        op_idle(); settle();
        check("R1 irq_std", {7'b0, irq_std}, 8'h00);
        check("R1 irq_bx", {7'b0, irq_bx}, 8'h00);
        check("R1 cmd_valid", {7'b0, cmd_valid}, 8'h00);
        check("R1 hold/stop", {6'b0, proc_hold, eng_stop}, 8'h00);
        op_rd(8'h0C, 8'h00, "R1 status");
        op_rd(8'h0A, 8'h00, "R1 data");
        op_rd(8'h0E, 8'h00, "R1 ack1");
        op_rd(8'h0F, 8'h00, "R1 ack2");

        // R2 and R3: command strobe, busy, done
        op_wr(8'h0C, 8'hD1);
        op_idle(); settle();
        check("R2 cmd_valid", {7'b0, cmd_valid}, 8'h01);
        check("R2 cmd_byte", cmd_byte, 8'hD1);
        op_rd(8'h0C, 8'h80, "R3 busy set");
        settle();
        check("R2 strobe one cycle", {7'b0, cmd_valid}, 8'h00);
        op_done();
        op_rd(8'h0C, 8'h00, "R3 done clears");

        // R3: write and done in the same cycle keeps busy
        @(negedge clk); clear_inputs();
        host_addr = 8'h0D; host_wdata = 8'h33; host_wr = 1; proc_done = 1;
        op_rd(8'h0D, 8'h80, "R3 write beats done");
        op_done();

        // R4: four status polls free busy
        op_wr(8'h0D, 8'h40);
        op_idle(); settle();
        check("R2 alias cmd_byte", cmd_byte, 8'h40);
        op_rd(8'h0C, 8'h80, "R4 poll1");
        op_rd(8'h0C, 8'h80, "R4 poll2");
        op_rd(8'h0D, 8'h80, "R4 poll3");
        op_rd(8'h0C, 8'h80, "R4 poll4");
        op_rd(8'h0C, 8'h00, "R4 after poll4");

        // R5: push and read
        op_push(8'h5A);
        op_rd(8'h0E, 8'h80, "R5 ack1 ready");
        op_rd(8'h0F, 8'h80, "R5 ack2 ready");
        op_rd(8'h0A, 8'h5A, "R5 data byte");
        op_rd(8'h0E, 8'h00, "R5 ready cleared");
        op_rd(8'h0F, 8'h00, "R5 ready cleared 2");

        // R6: overwrite
        op_push(8'h11);
        op_push(8'h22);
        op_rd(8'h0E, 8'h80, "R6 still ready");
        op_rd(8'h0B, 8'h22, "R6 newest byte");
        op_rd(8'h0F, 8'h00, "R6 cleared");

        // R7: interrupt classes
        op_raise(1, 0);
        op_idle(); settle();
        check("R7 std raised", {6'b0, irq_bx, irq_std}, 8'h01);
        op_rd(8'h0F, 8'h00, "R7 wrong ack read");
        op_idle(); settle();
        check("R7 bx ack leaves std", {6'b0, irq_bx, irq_std}, 8'h01);
        op_rd(8'h0E, 8'h00, "R7 std ack read");
        op_idle(); settle();
        check("R7 std acked", {6'b0, irq_bx, irq_std}, 8'h00);
        op_raise(0, 1);
        op_rd(8'h0E, 8'h00, "R7 std ack on bx");
        op_idle(); settle();
        check("R7 std ack leaves bx", {6'b0, irq_bx, irq_std}, 8'h02);
        @(negedge clk); clear_inputs();
        host_addr = 8'h0F; host_rd = 1; proc_irq_bx = 1;
        exp_q.push_back(8'h00); tag_q.push_back("R7 ack with raise read");
        op_idle(); settle();
        check("R7 raise beats ack", {6'b0, irq_bx, irq_std}, 8'h02);
        op_rd(8'h0F, 8'h00, "R7 bx ack read");
        op_idle(); settle();
        check("R7 bx acked", {6'b0, irq_bx, irq_std}, 8'h00);

        // R8: reset state clears everything
        op_wr(8'h0C, 8'h10);
        op_push(8'h77);
        op_raise(1, 1);
        op_wr(8'h06, 8'h01);
        op_idle(); settle();
        check("R8 hold and stop", {6'b0, proc_hold, eng_stop}, 8'h03);
        check("R8 irqs cleared", {6'b0, irq_bx, irq_std}, 8'h00);
        op_rd(8'h0C, 8'h00, "R8 busy cleared");
        settle();
        check("R8 stop one cycle", {7'b0, eng_stop}, 8'h00);
        op_rd(8'h0E, 8'h00, "R8 ready cleared");

        // R9: held state ignores commands and raises
        op_wr(8'h0C, 8'h55);
        op_idle(); settle();
        check("R9 no strobe", {7'b0, cmd_valid}, 8'h00);
        op_rd(8'h0C, 8'h00, "R9 no busy");
        op_raise(1, 1);
        op_idle(); settle();
        check("R9 irqs quiet", {6'b0, irq_bx, irq_std}, 8'h00);
        op_wr(8'h07, 8'h01);
        op_idle(); settle();
        check("R8 re-enter no stop", {6'b0, proc_hold, eng_stop}, 8'h02);
        op_wr(8'h07, 8'h00);
        op_idle(); settle();
        check("R8 leave hold", {7'b0, proc_hold}, 8'h00);
        op_wr(8'h0C, 8'h66);
        op_idle(); settle();
        check("R8 commands resume", cmd_byte, 8'h66);

        // R10: unmapped offsets
        op_done();
        op_wr(8'h03, 8'h99);
        op_idle(); settle();
        check("R10 unmapped write", {7'b0, cmd_valid}, 8'h00);
        op_wr(8'h1C, 8'h99);
        op_idle(); settle();
        check("R10 upper nibble write", {7'b0, cmd_valid}, 8'h00);
        op_rd(8'h0C, 8'h00, "R10 status idle");
        op_push(8'hC3);
        op_rd(8'h03, 8'h00, "R10 unmapped read");
        op_rd(8'h1A, 8'h00, "R10 upper nibble read");
        op_rd(8'h0E, 8'h80, "R10 reserved bits");
        op_idle(); op_idle();

        check("scoreboard drained", 8'(exp_q.size()), 8'h00);
        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule